// File: doc/BRIEF.md
# Modular Exponentiation Sequencer with Shared Operand Memory

This block runs a left-to-right binary exponentiation, Z = X^E mod M. It does this by sending a series of square and multiply commands to an external Montgomery multiplier. A host loads the message, the exponent, the modulus and the Montgomery form of one into a word-addressed operand memory. It sets the key length in words and writes a start bit. While the operation runs, the host polls a status word. When the operation ends, the host reads the result from the Z region.

The operand memory has a single port. A round-robin arbiter shares it between the host and the datapath. Host traffic therefore delays datapath accesses by at most one slot and never stops them. The datapath port belongs to the sequencer in some states and to the multiplier in others. The sequencer uses it to copy the unit value into Z and to fetch exponent words. While a multiplier command is outstanding, the multiplier uses the same port to read Z, X and M and to write Z back. Computing the Montgomery constants is left to the host.

The controller is a single state machine:
- States: `S_IDLE`, `S_COPY_RD`, `S_COPY_CAP`, `S_COPY_WR`, `S_EXP_RD`, `S_EXP_CAP`, `S_BIT`, `S_SQ_GO`, `S_SQ_WAIT`, `S_MUL_GO`, `S_MUL_WAIT`, `S_NEXT`, `S_DONE`.
- Setup transitions: idle to copy-read on start. Copy-read to copy-capture on grant. Copy-capture to copy-write. Copy-write to the next copy-read on grant, or to exponent-read after the last word.
- Exponent fetch: exponent-read to exponent-capture on grant. Exponent-capture goes to `S_DONE` when a leading zero word is the lowest word, to the next exponent-read for any other leading zero word, and otherwise to bit-test.
- Bit handling: bit-test goes to `S_NEXT` for a leading zero bit, and otherwise to square-issue. Square-issue goes to square-wait. Square-wait goes to multiply-issue or to next when the multiplier reports done. Multiply-issue goes to multiply-wait, and multiply-wait goes to next when done.
- Loop and finish: next goes to bit-test, to exponent-read, or to `S_DONE`. `S_DONE` goes to idle.

Top module: `expo_ctrl`

## Requirements
- R1: The address is {region[2:0], offset[LOG_W-1:0]}. Regions are 0 message X, 1 exponent E, 2 modulus M, 3 result Z, 4 unit (Montgomery one), and 5 control. Operand word 0 is the least significant. Control offset 0 reads busy in bit 0 and done in bit 1, and a write with bit 0 set is a start. Control offset 1 holds the key length in words and resets to 1. Read data appears together with `host_rvalid` one cycle after the grant.
- R2: At most one of host and datapath is granted per cycle. When both request, the grant alternates. A host request that loses is granted in the next cycle.
- R3: A start written while idle makes the block busy on the next cycle. Before any command is issued, the block copies the unit region into Z over the key length.
- R4: The exponent bits are scanned from the most significant set bit of the key-length-wide exponent down to bit 0. Each bit issues a square (`mul_op`=0). Each 1 bit then issues a multiply by X (`mul_op`=1). The final Z equals X^E mod M in the multiplier's domain.
- R5: `mul_start` pulses only while busy. No new command starts until the multiplier raises `mul_done` for the previous one.
- R6: Leading zero bits and leading zero words cost no commands. An exponent of 3 costs 2 squares and 2 multiplies, and an exponent of 17 costs 5 squares and 2 multiplies.
- R7: A zero exponent finishes with Z equal to the unit value and with no command issued.
- R8: While busy, host writes to regions 0 to 4 and to the key length are ignored. Host reads still complete.
- R9: The engine port is granted only while a multiplier command is outstanding.
- R10: Done is set when an operation finishes and cleared by the next start. Done and busy are never both set.
- R11: The key length sets the word count of the copy, the exponent scan and `mul_len`. Exponent words at or above the key length are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_req | input | 1 | Host access request, held until granted |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | WORD_W | Host write data |
| host_gnt | output | 1 | Host access taken this cycle |
| host_rvalid | output | 1 | Host read data valid |
| host_rdata | output | WORD_W | Host read data |
| mul_start | output | 1 | Command pulse to the multiplier |
| mul_op | output | 1 | 0 square Z, 1 multiply Z by X |
| mul_len | output | LEN_W | Operand length in words |
| mul_done | input | 1 | Multiplier finished the current command |
| eng_req | input | 1 | Multiplier memory request |
| eng_we | input | 1 | Multiplier write (1) or read (0) |
| eng_addr | input | ADDR_W | Multiplier word address |
| eng_wdata | input | WORD_W | Multiplier write data |
| eng_gnt | output | 1 | Multiplier access taken this cycle |
| eng_rvalid | output | 1 | Multiplier read data valid |
| eng_rdata | output | WORD_W | Multiplier read data |

## Verification
The exponent patterns are chosen so that each one separates a different scanning fault:
- 3 and 17 separate a correct scan start from one that begins at the top bit or misses the interleaved multiplies.
- A 64-bit exponent with many set bits spans all four words and exposes word-index and bit-index errors.
- Zero shows that the unit copy alone defines the result.
- A nonzero word above a one-word key length shows whether the scan honours the key length.

Each run is also repeated with host writes and status polls issued while the block is busy. This separates correct write protection and fair arbitration from designs that let late writes corrupt operands or that starve the host.

// File: rtl/expo_pkg.sv
package expo_pkg;

    typedef enum logic [2:0] {
        RG_X    = 3'd0,
        RG_E    = 3'd1,
        RG_M    = 3'd2,
        RG_Z    = 3'd3,
        RG_UNIT = 3'd4,
        RG_CSR  = 3'd5
    } region_e;

    localparam int unsigned NUM_MEM_REGIONS = 5;

    typedef enum logic [3:0] {
        S_IDLE,
        S_COPY_RD,
        S_COPY_CAP,
        S_COPY_WR,
        S_EXP_RD,
        S_EXP_CAP,
        S_BIT,
        S_SQ_GO,
        S_SQ_WAIT,
        S_MUL_GO,
        S_MUL_WAIT,
        S_NEXT,
        S_DONE
    } seq_state_e;

endpackage

// File: rtl/expo_rr_arb.sv
module expo_rr_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic req_a,
    input  logic req_b,
    output logic gnt_a,
    output logic gnt_b
);
    logic last_a;

    always_comb begin
        gnt_a = req_a && (!req_b || !last_a);
        gnt_b = req_b && !gnt_a;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_a <= 1'b0;
        end else if (gnt_a) begin
            last_a <= 1'b1;
        end else if (gnt_b) begin
            last_a <= 1'b0;
        end
    end
endmodule

// File: rtl/expo_opram.sv
module expo_opram #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned DEPTH  = 20,
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  rdata
);
    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                cells[addr] <= wdata;
            end else begin
                rdata <= cells[addr];
            end
        end
    end
endmodule

// File: rtl/expo_fsm.sv
module expo_fsm
    import expo_pkg::*;
#(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned LOG_W  = 2,
    parameter int unsigned LEN_W  = 3,
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  key_len,
    input  logic              seq_gnt,
    input  logic [WORD_W-1:0] rdata,
    input  logic              mul_done,
    output logic              seq_req,
    output logic              seq_we,
    output logic [ADDR_W-1:0] seq_addr,
    output logic [WORD_W-1:0] seq_wdata,
    output logic              mul_start,
    output logic              mul_op,
    output logic              eng_own,
    output logic              busy,
    output logic              finish
);
    localparam int unsigned BIT_W = $clog2(WORD_W);

    seq_state_e state, state_nx;

    logic [LOG_W-1:0]  idx;
    logic [BIT_W-1:0]  bidx;
    logic [WORD_W-1:0] ebuf;
    logic [WORD_W-1:0] cbuf;
    logic              seen;
    logic              idx_last;
    logic              cur_bit;

    assign idx_last = ({1'b0, idx} == (key_len - LEN_W'(1)));
    assign cur_bit  = ebuf[bidx];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:     if (start) state_nx = S_COPY_RD;
            S_COPY_RD:  if (seq_gnt) state_nx = S_COPY_CAP;
            S_COPY_CAP: state_nx = S_COPY_WR;
            S_COPY_WR:  if (seq_gnt) state_nx = idx_last ? S_EXP_RD : S_COPY_RD;
            S_EXP_RD:   if (seq_gnt) state_nx = S_EXP_CAP;
            S_EXP_CAP: begin
                if (!seen && rdata == '0) begin
                    state_nx = (idx == '0) ? S_DONE : S_EXP_RD;
                end else begin
                    state_nx = S_BIT;
                end
            end
            S_BIT:      state_nx = (!seen && !cur_bit) ? S_NEXT : S_SQ_GO;
            S_SQ_GO:    state_nx = S_SQ_WAIT;
            S_SQ_WAIT:  if (mul_done) state_nx = cur_bit ? S_MUL_GO : S_NEXT;
            S_MUL_GO:   state_nx = S_MUL_WAIT;
            S_MUL_WAIT: if (mul_done) state_nx = S_NEXT;
            S_NEXT: begin
                if (bidx != '0) begin
                    state_nx = S_BIT;
                end else begin
                    state_nx = (idx == '0) ? S_DONE : S_EXP_RD;
                end
            end
            S_DONE:     state_nx = S_IDLE;
            default:    state_nx = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx  <= '0;
            bidx <= '0;
            ebuf <= '0;
            cbuf <= '0;
            seen <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        idx  <= '0;
                        seen <= 1'b0;
                    end
                end
                S_COPY_CAP: cbuf <= rdata;
                S_COPY_WR: begin
                    if (seq_gnt) begin
                        idx <= idx_last ? LOG_W'(key_len - LEN_W'(1)) : idx + LOG_W'(1);
                    end
                end
                S_EXP_CAP: begin
                    ebuf <= rdata;
                    bidx <= BIT_W'(WORD_W - 1);
                    if (!seen && rdata == '0 && idx != '0) begin
                        idx <= idx - LOG_W'(1);
                    end
                end
                S_BIT: begin
                    if (seen || cur_bit) begin
                        seen <= 1'b1;
                    end
                end
                S_NEXT: begin
                    if (bidx != '0) begin
                        bidx <= bidx - BIT_W'(1);
                    end else if (idx != '0) begin
                        idx <= idx - LOG_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        seq_req   = 1'b0;
        seq_we    = 1'b0;
        seq_addr  = '0;
        seq_wdata = cbuf;
        mul_start = 1'b0;
        mul_op    = 1'b0;
        eng_own   = 1'b0;
        busy      = (state != S_IDLE);
        finish    = (state == S_DONE);
        unique case (state)
            S_COPY_RD: begin
                seq_req  = 1'b1;
                seq_addr = {RG_UNIT, idx};
            end
            S_COPY_WR: begin
                seq_req  = 1'b1;
                seq_we   = 1'b1;
                seq_addr = {RG_Z, idx};
            end
            S_EXP_RD: begin
                seq_req  = 1'b1;
                seq_addr = {RG_E, idx};
            end
            S_SQ_GO:    mul_start = 1'b1;
            S_SQ_WAIT:  eng_own   = 1'b1;
            S_MUL_GO: begin
                mul_start = 1'b1;
                mul_op    = 1'b1;
            end
            S_MUL_WAIT: begin
                mul_op  = 1'b1;
                eng_own = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/expo_ctrl.sv
module expo_ctrl
    import expo_pkg::*;
#(
    parameter int unsigned WORD_W    = 16,
    parameter int unsigned MAX_WORDS = 4,
    parameter int unsigned LOG_W     = $clog2(MAX_WORDS),
    parameter int unsigned ADDR_W    = LOG_W + 3,
    parameter int unsigned LEN_W     = LOG_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic              host_gnt,
    output logic              host_rvalid,
    output logic [WORD_W-1:0] host_rdata,
    output logic              mul_start,
    output logic              mul_op,
    output logic [LEN_W-1:0]  mul_len,
    input  logic              mul_done,
    input  logic              eng_req,
    input  logic              eng_we,
    input  logic [ADDR_W-1:0] eng_addr,
    input  logic [WORD_W-1:0] eng_wdata,
    output logic              eng_gnt,
    output logic              eng_rvalid,
    output logic [WORD_W-1:0] eng_rdata
);
    localparam int unsigned DEPTH = NUM_MEM_REGIONS * MAX_WORDS;

    logic [2:0]        h_region;
    logic [LOG_W-1:0]  h_off;
    logic              h_is_csr;
    logic              busy;
    logic              finish;
    logic              start_pulse;
    logic              done_q;
    logic [LEN_W-1:0]  keylen_q;
    logic              csr_hit_q;
    logic [WORD_W-1:0] csr_val_q;
    logic              dp_rvalid_q;
    logic              host_rvalid_q;

    logic              seq_req, seq_we, eng_own, seq_gnt;
    logic [ADDR_W-1:0] seq_addr;
    logic [WORD_W-1:0] seq_wdata;
    logic              dp_req, dp_we, dp_gnt;
    logic [ADDR_W-1:0] dp_addr;
    logic [WORD_W-1:0] dp_wdata;

    logic              mem_en, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [WORD_W-1:0] mem_wdata, mem_rdata;

    assign h_region = host_addr[ADDR_W-1 -: 3];
    assign h_off    = host_addr[LOG_W-1:0];
    assign h_is_csr = (h_region == RG_CSR);

    // datapath port ownership
    assign dp_req   = eng_own ? eng_req   : seq_req;
    assign dp_we    = eng_own ? eng_we    : seq_we;
    assign dp_addr  = eng_own ? eng_addr  : seq_addr;
    assign dp_wdata = eng_own ? eng_wdata : seq_wdata;
    assign seq_gnt  = dp_gnt && !eng_own;
    assign eng_gnt  = dp_gnt && eng_own;

    expo_rr_arb u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req_a (host_req),
        .req_b (dp_req),
        .gnt_a (host_gnt),
        .gnt_b (dp_gnt)
    );

    always_comb begin
        mem_en    = host_gnt || dp_gnt;
        mem_we    = 1'b0;
        mem_addr  = dp_addr;
        mem_wdata = dp_wdata;
        if (host_gnt) begin
            mem_we    = host_we && (h_region < 3'(NUM_MEM_REGIONS)) && !busy;
            mem_addr  = host_addr;
            mem_wdata = host_wdata;
        end else if (dp_gnt) begin
            mem_we = dp_we;
        end
    end

    expo_opram #(
        .WIDTH  (WORD_W),
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_ram (
        .clk   (clk),
        .en    (mem_en),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    assign start_pulse = host_gnt && host_we && h_is_csr && (h_off == '0)
                         && host_wdata[0] && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            keylen_q      <= LEN_W'(1);
            done_q        <= 1'b0;
            csr_hit_q     <= 1'b0;
            csr_val_q     <= '0;
            host_rvalid_q <= 1'b0;
            dp_rvalid_q   <= 1'b0;
        end else begin
            host_rvalid_q <= host_gnt && !host_we;
            dp_rvalid_q   <= dp_gnt && !dp_we;
            if (host_gnt && host_we && h_is_csr && (h_off == LOG_W'(1)) && !busy) begin
                keylen_q <= host_wdata[LEN_W-1:0];
            end
            if (start_pulse) begin
                done_q <= 1'b0;
            end else if (finish) begin
                done_q <= 1'b1;
            end
            if (host_gnt && !host_we) begin
                csr_hit_q <= h_is_csr;
                csr_val_q <= (h_off == '0) ? WORD_W'({done_q, busy}) : WORD_W'(keylen_q);
            end
        end
    end

    expo_fsm #(
        .WORD_W (WORD_W),
        .LOG_W  (LOG_W),
        .LEN_W  (LEN_W),
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_pulse),
        .key_len   (keylen_q),
        .seq_gnt   (seq_gnt),
        .rdata     (mem_rdata),
        .mul_done  (mul_done),
        .seq_req   (seq_req),
        .seq_we    (seq_we),
        .seq_addr  (seq_addr),
        .seq_wdata (seq_wdata),
        .mul_start (mul_start),
        .mul_op    (mul_op),
        .eng_own   (eng_own),
        .busy      (busy),
        .finish    (finish)
    );

    assign host_rvalid = host_rvalid_q;
    assign host_rdata  = csr_hit_q ? csr_val_q : mem_rdata;
    assign eng_rvalid  = dp_rvalid_q;
    assign eng_rdata   = mem_rdata;
    assign mul_len     = keylen_q;
endmodule

// File: rtl/expo_ctrl_chk.sv
module expo_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic host_req,
    input logic host_gnt,
    input logic dp_req,
    input logic dp_gnt,
    input logic start_pulse,
    input logic busy,
    input logic done_q,
    input logic mul_start,
    input logic mul_done,
    input logic eng_gnt
);
    logic outst;
    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            outst   <= 1'b0;
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            if (mul_start) begin
                outst <= 1'b1;
            end else if (mul_done) begin
                outst <= 1'b0;
            end
        end
    end

    p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_gnt && dp_gnt));

    p_rr_alt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && host_req && dp_req && $past(host_gnt && dp_req)) |-> !host_gnt);

    p_host_served_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_gnt) |=> (!host_req || host_gnt));

    p_busy_after_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> busy);

    p_cmd_when_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mul_start |-> busy);

    p_single_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mul_start |-> !outst);

    p_eng_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eng_gnt |-> outst);

    p_done_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_q && busy));
endmodule

bind expo_ctrl expo_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_req    (host_req),
    .host_gnt    (host_gnt),
    .dp_req      (dp_req),
    .dp_gnt      (dp_gnt),
    .start_pulse (start_pulse),
    .busy        (busy),
    .done_q      (done_q),
    .mul_start   (mul_start),
    .mul_done    (mul_done),
    .eng_gnt     (eng_gnt)
);

// File: tb/expo_ctrl_bench.sv
`timescale 1ns/1ps
module expo_ctrl_bench;
    localparam int WORD_W = 16;
    localparam int MAXW   = 4;
    localparam int ADDR_W = 5;
    localparam int LEN_W  = 3;
    localparam int RX = 0, RE = 1, RM = 2, RZ = 3, RU = 4, RC = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_req = 1'b0, host_we = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [WORD_W-1:0] host_wdata = '0;
    logic              host_gnt, host_rvalid;
    logic [WORD_W-1:0] host_rdata;
    logic              mul_start, mul_op;
    logic [LEN_W-1:0]  mul_len;
    logic              mul_done = 1'b0;
    logic              eng_req = 1'b0, eng_we = 1'b0;
    logic [ADDR_W-1:0] eng_addr = '0;
    logic [WORD_W-1:0] eng_wdata = '0;
    logic              eng_gnt, eng_rvalid;
    logic [WORD_W-1:0] eng_rdata;

    int checks = 0, failures = 0;
    int sq_cnt = 0, mu_cnt = 0;
    int max_wait = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    expo_ctrl u_expo_ctrl (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_gnt(host_gnt), .host_rvalid(host_rvalid),
        .host_rdata(host_rdata),
        .mul_start(mul_start), .mul_op(mul_op), .mul_len(mul_len), .mul_done(mul_done),
        .eng_req(eng_req), .eng_we(eng_we), .eng_addr(eng_addr), .eng_wdata(eng_wdata),
        .eng_gnt(eng_gnt), .eng_rvalid(eng_rvalid), .eng_rdata(eng_rdata)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] ad(input int region, input int off);
        return ADDR_W'(region * MAXW + off);
    endfunction

    task automatic host_acc(input bit we, input logic [ADDR_W-1:0] a,
                            input logic [WORD_W-1:0] d, output logic [WORD_W-1:0] q);
        int waits = 0;
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
        #1;
        while (!host_gnt) begin
            @(negedge clk);
            waits++;
            #1;
        end
        if (waits > max_wait) max_wait = waits;
        @(negedge clk);
        q = host_rdata;
        if (!we && !host_rvalid) q = 'x;
        host_req = 1'b0; host_we = 1'b0;
    endtask

    task automatic hwr(input int region, input int off, input logic [WORD_W-1:0] d);
        logic [WORD_W-1:0] q;
        host_acc(1'b1, ad(region, off), d, q);
    endtask

    task automatic hrd(input int region, input int off, output logic [WORD_W-1:0] q);
        host_acc(1'b0, ad(region, off), '0, q);
    endtask

    task automatic hwr_val(input int region, input logic [63:0] v);
        for (int i = 0; i < MAXW; i++) hwr(region, i, v[i*16 +: 16]);
    endtask

    task automatic hrd_val(input int region, input int len, output logic [63:0] v);
        logic [WORD_W-1:0] q;
        v = '0;
        for (int i = 0; i < len; i++) begin
            hrd(region, i, q);
            v[i*16 +: 16] = q;
        end
    endtask

    // multiplier model: plain modular product, unit value is 1
    task automatic eng_acc(input bit we, input logic [ADDR_W-1:0] a,
                           input logic [WORD_W-1:0] d, output logic [WORD_W-1:0] q);
        @(negedge clk);
        eng_req = 1'b1; eng_we = we; eng_addr = a; eng_wdata = d;
        #1;
        while (!eng_gnt) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        q = eng_rdata;
        eng_req = 1'b0; eng_we = 1'b0;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (mul_start) begin
                logic [63:0] z, x, m;
                logic [127:0] p;
                logic [WORD_W-1:0] q;
                bit op;
                int len;
                op = mul_op;
                len = int'(mul_len);
                z = '0; x = '0; m = '0;
                for (int i = 0; i < len; i++) begin
                    eng_acc(1'b0, ad(RZ, i), '0, q); z[i*16 +: 16] = q;
                    eng_acc(1'b0, ad(RM, i), '0, q); m[i*16 +: 16] = q;
                    if (op) begin
                        eng_acc(1'b0, ad(RX, i), '0, q); x[i*16 +: 16] = q;
                    end
                end
                p = op ? (128'(z) * 128'(x)) % 128'(m) : (128'(z) * 128'(z)) % 128'(m);
                for (int i = 0; i < len; i++) eng_acc(1'b1, ad(RZ, i), p[i*16 +: 16], q);
                if (op) mu_cnt++; else sq_cnt++;
                mul_done = 1'b1;
                @(posedge clk);
                #1 mul_done = 1'b0;
            end
        end
    end

    function automatic logic [63:0] ref_exp(input logic [63:0] x, input logic [63:0] e,
                                            input logic [63:0] m, input int len,
                                            output int sq, output int mu);
        logic [127:0] z = 128'd1;
        bit seen = 1'b0;
        sq = 0; mu = 0;
        for (int b = len * 16 - 1; b >= 0; b--) begin
            if (e[b]) seen = 1'b1;
            if (seen) begin
                z = (z * z) % 128'(m); sq++;
                if (e[b]) begin z = (z * 128'(x)) % 128'(m); mu++; end
            end
        end
        return z[63:0];
    endfunction

    task automatic wait_done();
        logic [WORD_W-1:0] s;
        do hrd(RC, 0, s); while (s[1] == 1'b0);
    endtask

    task automatic run_case(input string req, input logic [63:0] x, input logic [63:0] e,
                            input logic [63:0] m, input int len);
        logic [63:0] z, zexp;
        int sq, mu;
        zexp = ref_exp(x, e, m, len, sq, mu);
        hwr_val(RX, x); hwr_val(RE, e); hwr_val(RM, m);
        hwr_val(RU, 64'd1); hwr_val(RZ, 64'h5a5a_5a5a_5a5a_5a5a);
        hwr(RC, 1, 16'(len));
        sq_cnt = 0; mu_cnt = 0;
        hwr(RC, 0, 16'd1);
        wait_done();
        hrd_val(RZ, len, z);
        chk(z == zexp, req, z, zexp);
        chk(sq_cnt == sq, {req, " squares"}, sq_cnt, sq);
        chk(mu_cnt == mu, {req, " multiplies"}, mu_cnt, mu);
    endtask

    task automatic t_reset();
        logic [WORD_W-1:0] q;
        hrd(RC, 0, q); chk(q == 16'd0, "R10 reset status", q, 0);
        hrd(RC, 1, q); chk(q == 16'd1, "R1 reset key length", q, 1);
    endtask

    task automatic t_map();
        logic [WORD_W-1:0] q;
        hwr(RX, 2, 16'hbeef); hwr(RM, 3, 16'h1234);
        hrd(RX, 2, q); chk(q == 16'hbeef, "R1 X readback", q, 16'hbeef);
        hrd(RM, 3, q); chk(q == 16'h1234, "R1 M readback", q, 16'h1234);
    endtask

    task automatic t_small();
        run_case("R6 e=3", 64'd5, 64'd3, 64'd1009, 1);
        run_case("R6 e=17", 64'd2, 64'd17, 64'd100003, 2);
        run_case("R4 long", 64'h0123_4567_89ab_cdef, 64'hf00d_0000_8421_0001,
                 64'hffff_ffff_ffff_ffc5, 4);
    endtask

    task automatic t_zero();
        run_case("R7 e=0", 64'd77, 64'd0, 64'd1009, 2);
    endtask

    task automatic t_keylen();
        // E word 1 nonzero but ignored with a one-word key
        run_case("R11 keylen", 64'd7, 64'h0000_0000_ffff_0005, 64'd65521, 1);
    endtask

    task automatic t_protect();
        logic [WORD_W-1:0] q;
        logic [63:0] z, zexp;
        int sq, mu;
        logic [63:0] x = 64'h0000_0003_0000_0011;
        logic [63:0] e = 64'h8000_0000_0000_0003;
        logic [63:0] m = 64'hffff_ffff_ffff_ffc5;
        zexp = ref_exp(x, e, m, 4, sq, mu);
        hwr_val(RX, x); hwr_val(RE, e); hwr_val(RM, m); hwr_val(RU, 64'd1);
        hwr(RC, 1, 16'd4);
        hwr(RC, 0, 16'd1);
        hrd(RC, 0, q); chk(q == 16'd1, "R10 busy set, done clear", q, 1);
        max_wait = 0;
        hwr(RX, 0, 16'h0);
        hwr(RE, 3, 16'h0);
        hwr(RC, 1, 16'd1);
        wait_done();
        chk(max_wait <= 1, "R2 host wait bound", max_wait, 1);
        hrd(RC, 0, q); chk(q == 16'd2, "R10 done status", q, 2);
        hrd(RX, 0, q); chk(q == 16'h0011, "R8 X write ignored", q, 16'h0011);
        hrd(RC, 1, q); chk(q == 16'd4, "R8 key length write ignored", q, 4);
        hrd_val(RZ, 4, z); chk(z == zexp, "R8 result with protected operands", z, zexp);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_small();
        t_zero();
        t_keylen();
        t_protect();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule